// File: doc/BRIEF.md
# Serial EEPROM Target Addressing Front End

This block is the bus-facing side of a two-wire serial EEPROM. It oversamples the clock and data lines with the system clock and recognises START and STOP conditions. It then takes in a control byte followed by up to two word-address bytes. It acknowledges by pulling the data line low through an open-drain enable. Data bytes that arrive after the address are written into an internal byte array. A read control byte makes the block shift bytes out of the same array.

The array has two halves. A bit of the control byte picks the half, so the top address bit never comes from the address bytes. A counter steps through the lower address bits after every byte, in both directions, and wraps at the end of the selected half. The usual access pattern is a random read: write the control byte and both address bytes, issue a repeated START, send a read control byte, then clock out as many bytes as needed. The controller ends the read with a not-acknowledge and a STOP. Writes land in the array at once; no programming delay is modelled.

Top module: `ee_serial_target`

## Requirements
- R1: After reset the block releases the data line (`sda_pull` low) and waits for a START.
- R2: The block acknowledges a control byte only when bits 7:4 equal 1010 and bits 2:1 equal `strap_cs`. Otherwise it never pulls the data line low until the next START.
- R3: Control byte bit 0 selects the direction: 1 makes the block transmit data bytes, and 0 makes it take in address bytes followed by data bytes.
- R4: For a write, the high address byte arrives first and the low byte second. They form a 15-bit word {high[6:0], low[7:0]}, and its lower `HALF_AW` bits become the in-half address. High bit 7 is ignored.
- R5: Each data byte received after the two address bytes is stored at the current address, acknowledged, and followed by an address increment.
- R6: Control byte bit 3 is the top array address bit and selects one of the two halves for both reads and writes.
- R7: The in-half address wraps from all ones to zero and never carries into the half-select bit.
- R8: After a repeated START and a read control byte, the block returns the byte at the loaded address first and then the following addresses, one per byte.
- R9: A not-acknowledge from the controller after a read byte ends the transfer. The block keeps the data line released until the next START.
- R10: The block changes its data-line drive only while the clock line is low. Every byte is sent most significant bit first.
- R11: A STOP at any point returns the block to idle. A partly received address byte is discarded and the address is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_cs | input | 2 | Chip-select strap levels compared against control byte bits 2:1 |
| sda_pull | output | 1 | When high, the data line is pulled low (open-drain enable) |

## Verification
The bench builds the block with `HALF_AW` = 9, which gives a 1 KiB array with 512-byte halves. At that size a run of a few dozen bytes crosses the wrap point of each half, and bit 0 of the high address byte becomes address bit 8, so swapping the two address bytes would read from the wrong location. The bench sends all 256 control byte values against one strap setting and tries every strap setting with a matching and a mismatching select field. The two halves are filled with patterns that differ, so a carry into the half-select bit shows up as wrong data.

// File: rtl/ee_tgt_pkg.sv
`timescale 1ns/1ps
package ee_tgt_pkg;
  // bus transfer phase
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} st_e;
  // meaning of the byte currently being received
  typedef enum logic [1:0] {RL_CTRL, RL_AHI, RL_ALO, RL_DATA} role_e;
  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/ee_bus_sampler.sv
`timescale 1ns/1ps
module ee_bus_sampler #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_N-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_N-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_N-2:0], sda_i};
      scl_q    <= scl_pipe[SYNC_N-1];
      sda_q    <= sda_pipe[SYNC_N-1];
    end
  end

  assign scl_lvl  = scl_pipe[SYNC_N-1];
  assign sda_lvl  = sda_pipe[SYNC_N-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_o  = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_o   = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/ee_addr_ctr.sv
`timescale 1ns/1ps
module ee_addr_ctr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_we,
  input  logic          blk_d,
  input  logic          low_we,
  input  logic [AW-1:0] low_d,
  input  logic          inc,
  output logic [AW:0]   addr_o
);
  logic          blk_q, blk_n;
  logic [AW-1:0] low_q, low_n;

  always_comb begin
    blk_n = blk_we ? blk_d : blk_q;
    low_n = low_q;
    if (low_we)   low_n = low_d;
    else if (inc) low_n = low_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      low_q <= '0;
    end else begin
      blk_q <= blk_n;
      low_q <= low_n;
    end
  end

  assign addr_o = {blk_q, low_q};

  // R7
  blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !blk_we) |=> $stable(blk_q));

  // R7
  low_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !low_we && (low_q == {AW{1'b1}})) |=> (low_q == '0));
endmodule

// File: rtl/ee_mem_array.sv
`timescale 1ns/1ps
module ee_mem_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/ee_serial_target.sv
`timescale 1ns/1ps
module ee_serial_target
  import ee_tgt_pkg::*;
#(
  parameter int HALF_AW = 9,   // in-half address bits, 9..15
  parameter int SYNC_N  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] strap_cs,
  output logic       sda_pull
);
  localparam int FULL_AW = HALF_AW + 1;
  localparam int HI_W    = HALF_AW - 8;

  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_w, stop_w;
  ee_bus_sampler #(.SYNC_N(SYNC_N)) u_samp (
    .clk(clk), .rst_n(rst_i_n), .scl_i(scl_in), .sda_i(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_o(start_w), .stop_o(stop_w)
  );

  st_e   state_q, state_d;
  role_e role_q, role_d;
  logic       rd_q, rd_d, oe_q, oe_d, mack_q, mack_d;
  logic [3:0] bcnt_q, bcnt_d;
  logic [7:0] sh_q, sh_d, rdata;
  logic       blk_we, low_we, ahi_we, mem_we, inc, tx_load, match;
  logic [HI_W-1:0]    ahi_q;
  logic [HALF_AW-1:0] low_word;
  logic [FULL_AW-1:0] addr;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    ahi_q <= '0;
    else if (ahi_we) ahi_q <= sh_q[HI_W-1:0];
  end
  assign low_word = {ahi_q, sh_q};

  ee_addr_ctr #(.AW(HALF_AW)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .blk_we(blk_we), .blk_d(sh_q[3]),
    .low_we(low_we), .low_d(low_word), .inc(inc), .addr_o(addr)
  );

  ee_mem_array #(.AW(FULL_AW)) u_mem (
    .clk(clk), .we(mem_we), .addr(addr), .wdata(sh_q), .rdata(rdata)
  );

  assign match   = (sh_q[7:4] == DEV_CODE) && (sh_q[2:1] == strap_cs);
  assign tx_load = scl_fall && ((state_q == ST_ACK && rd_q) ||
                                (state_q == ST_MACK && mack_q));

  always_comb begin
    state_d = state_q;
    role_d  = role_q;
    rd_d    = rd_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    bcnt_d  = bcnt_q;
    sh_d    = sh_q;
    blk_we  = 1'b0;
    low_we  = 1'b0;
    ahi_we  = 1'b0;
    mem_we  = 1'b0;
    inc     = 1'b0;
    if (start_w) begin
      state_d = ST_RX;
      role_d  = RL_CTRL;
      bcnt_d  = 4'd0;
      oe_d    = 1'b0;
    end else if (stop_w) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (tx_load) begin
      sh_d    = {rdata[6:0], 1'b0};
      oe_d    = ~rdata[7];
      inc     = 1'b1;
      bcnt_d  = 4'd1;
      state_d = ST_TX;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            sh_d   = {sh_q[6:0], sda_lvl};
            bcnt_d = bcnt_q + 4'd1;
          end else if (scl_fall && bcnt_q == 4'd8) begin
            bcnt_d  = 4'd0;
            state_d = ST_ACK;
            oe_d    = 1'b1;
            case (role_q)
              RL_CTRL: begin
                if (match) begin
                  blk_we = 1'b1;
                  rd_d   = sh_q[0];
                end else begin
                  state_d = ST_IDLE;
                  oe_d    = 1'b0;
                end
              end
              RL_AHI:  ahi_we = 1'b1;
              RL_ALO:  low_we = 1'b1;
              default: begin
                mem_we = 1'b1;
                inc    = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_RX;
            case (role_q)
              RL_CTRL: role_d = RL_AHI;
              RL_AHI:  role_d = RL_ALO;
              default: role_d = RL_DATA;
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bcnt_q == 4'd8) begin
              oe_d    = 1'b0;
              bcnt_d  = 4'd0;
              state_d = ST_MACK;
            end else begin
              oe_d   = ~sh_q[7];
              sh_d   = {sh_q[6:0], 1'b0};
              bcnt_d = bcnt_q + 4'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) mack_d = ~sda_lvl;
          else if (scl_fall) state_d = ST_IDLE;
        end
        default: oe_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      role_q  <= RL_CTRL;
      rd_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
      bcnt_q  <= 4'd0;
      sh_q    <= 8'h00;
    end else begin
      state_q <= state_d;
      role_q  <= role_d;
      rd_q    <= rd_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
      bcnt_q  <= bcnt_d;
      sh_q    <= sh_d;
    end
  end

  assign sda_pull = oe_q;

  // R10
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!$stable(oe_q) && !$past(start_w || stop_w)) |-> !scl_lvl);

  // R2
  nomatch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_RX && role_q == RL_CTRL && scl_fall && bcnt_q == 4'd8 && !match)
      |=> !oe_q);

  // R9
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (state_q == ST_IDLE) |-> !oe_q);
endmodule

// File: tb/ee_serial_target_bench.sv
`timescale 1ns/1ps
module ee_serial_target_bench;
  localparam int HAW  = 9;
  localparam int HALF = 1 << HAW;
  localparam int Q    = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       ctl_oe = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       dut_oe;
  logic       sda_bus;
  assign sda_bus = ~(ctl_oe | dut_oe);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0, oe_viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [2*HALF];

  ee_serial_target #(.HALF_AW(HAW)) u_ee_serial_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .strap_cs(strap), .sda_pull(dut_oe)
  );

  always @(negedge clk) begin
    if (rst_n && (dut_oe !== prev_oe) && scl) oe_viol++;
    prev_oe = dut_oe;
  end

  function automatic logic [7:0] pat(input bit blk, input int a);
    return 8'(a * 37 + 11) ^ (blk ? 8'h5A : 8'h00);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic bus_start;
    ctl_oe = 1'b0; tick(Q);
    scl = 1'b1;    tick(Q);
    ctl_oe = 1'b1; tick(Q);
    scl = 1'b0;    tick(Q);
  endtask

  task automatic bus_stop;
    ctl_oe = 1'b1; tick(Q);
    scl = 1'b1;    tick(Q);
    ctl_oe = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input bit b);
    ctl_oe = ~b; tick(Q);
    scl = 1'b1;  tick(Q);
    scl = 1'b0;  tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    ctl_oe = 1'b0; tick(Q);
    scl = 1'b1; tick(2);
    acked = ~sda_bus;
    tick(Q - 2);
    scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    ctl_oe = 1'b0;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1'b1; tick(2);
      b = {b[6:0], sda_bus};
      tick(Q - 2);
      scl = 1'b0; tick(Q);
    end
    ctl_oe = give_ack; tick(Q);
    scl = 1'b1; tick(Q);
    scl = 1'b0; tick(Q);
    ctl_oe = 1'b0;
  endtask

  // control byte, then high and low address byte; high bit 7 and bits 6:1 outside the array set
  task automatic set_addr(input bit blk, input int a);
    bit ack;
    bus_start;
    send_byte({4'b1010, blk, strap, 1'b0}, ack);
    chk(ack, "R2 write control ack", ack, 1);
    send_byte({1'b1, 6'b101101, 1'(a >> 8)}, ack);
    chk(ack, "R4 high address ack", ack, 1);
    send_byte(8'(a), ack);
    chk(ack, "R4 low address ack", ack, 1);
  endtask

  task automatic write_run(input bit blk, input int a0, input int n);
    bit ack;
    set_addr(blk, a0);
    for (int k = 0; k < n; k++) begin
      int a = (a0 + k) % HALF;
      send_byte(pat(blk, a), ack);
      chk(ack, "R5 data ack", ack, 1);
      model[blk * HALF + a] = pat(blk, a);
    end
    bus_stop;
  endtask

  task automatic read_run(input bit blk, input int a0, input int n, input string tag);
    bit ack;
    logic [7:0] b;
    set_addr(blk, a0);
    bus_start;
    send_byte({4'b1010, blk, strap, 1'b1}, ack);
    chk(ack, "R3 read control ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      int idx = blk * HALF + (a0 + k) % HALF;
      recv_byte(k < n - 1, b);
      chk(b == model[idx], (k == 0) ? "R4 first byte at loaded address" : tag,
          b, model[idx]);
    end
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    // R1
    chk(dut_oe == 1'b0 && sda_bus == 1'b1, "R1 released after reset", dut_oe, 0);

    // R2: every control byte value against strap 2'b10
    strap = 2'b10;
    for (int c = 0; c < 256; c++) begin
      bit exp_ack;
      exp_ack = (c[7:4] == 4'b1010) && (c[2:1] == 2'b10);
      bus_start;
      send_byte(8'(c), ack);
      chk(ack == exp_ack, "R2 control byte decode", ack, exp_ack);
      if (ack && c[0]) recv_byte(1'b0, b);
      bus_stop;
    end

    // R2: each strap setting, matching and mismatching select
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      bus_start;
      send_byte({4'b1010, 1'b0, 2'(s), 1'b0}, ack);
      chk(ack, "R2 strap match", ack, 1);
      bus_stop;
      bus_start;
      send_byte({4'b1010, 1'b0, 2'(s) ^ 2'b01, 1'b0}, ack);
      chk(!ack, "R2 strap mismatch", ack, 0);
      bus_stop;
    end

    // R2: bytes after an unselected control byte get no acknowledge
    strap = 2'b00;
    bus_start;
    send_byte(8'b1010_0110, ack);
    chk(!ack, "R2 other device", ack, 0);
    send_byte(8'h01, ack);
    chk(!ack, "R2 ignored follow byte", ack, 0);
    send_byte(8'hF4, ack);
    chk(!ack, "R2 ignored follow byte", ack, 0);
    bus_stop;

    // R5 R6 R7: fill runs across the wrap of each half
    write_run(1'b0, 500, 26);
    write_run(1'b1, 505, 26);

    // R8 R7: random read in half 0 across the wrap
    read_run(1'b0, 500, 24, "R8 sequential read half 0");
    // R9: after the not-acknowledge the line stays released
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R9 silent after nack", b, 8'hFF);
    bus_stop;

    // R11: STOP inside the low address byte leaves the counter at 12
    bus_start;
    send_byte({4'b1010, 1'b0, strap, 1'b0}, ack);
    chk(ack, "R11 control ack", ack, 1);
    send_byte(8'h00, ack);
    chk(ack, "R11 high byte ack", ack, 1);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop;
    bus_start;
    send_byte({4'b1010, 1'b0, strap, 1'b1}, ack);
    chk(ack, "R11 read control ack", ack, 1);
    recv_byte(1'b0, b);
    chk(b == model[12], "R11 address kept after stop", b, model[12]);
    bus_stop;

    // R6 R7: half 1 read across the wrap, data differs from half 0
    read_run(1'b1, 505, 24, "R6 half 1 read");
    bus_stop;

    // R10
    chk(oe_viol == 0, "R10 drive changes only with clock low", oe_viol, 0);
    report;
  end

  initial begin
    tick(190000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    report;
  end
endmodule